// File: doc/BRIEF.md
# Frequency-Compensated Nanosecond Time Base

This block keeps the time of day for a precision clock as a 64-bit count of nanoseconds. On every reference clock cycle a 32-bit phase accumulator adds a programmable addend. Each carry out of the accumulator advances the counter by a fixed nanosecond step, which is the nominal period. The carry rate is therefore addend / 2^32 of the reference frequency. Software trims the clock rate by nudging the addend above or below its nominal value, ceil(2^32 x nominal_freq / reference_freq).

Software reaches the block through a small word-wide register port with four locations. Reads and writes of the 64-bit time go through two 32-bit locations, and the block makes each pair atomic. A read of the low word freezes a copy of the high word. A write of the low word is only staged, and the whole value is applied when the high word is written.

Top module: `ns_timebase`

## Requirements
- R1: After reset the counter, the accumulator, the enable bit, the period field and the addend are all zero, so every register reads back 0.
- R2: While enabled, on each clock edge the accumulator becomes (acc + addend) mod 2^32, and the carry out of that sum is a tick. After k edges from a cleared accumulator with a constant addend A, exactly floor(k*A/2^32) ticks have occurred.
- R3: On a tick the counter grows by the period field. On an edge without a tick and without a load it keeps its value.
- R4: Control register at address 0, bit 0 is the timer enable. While it is 0, neither the counter nor the accumulator changes. Writing 0 to the control register stops the timer.
- R5: The period field sits in control bits [16 +: PERIOD_W] (bits 23:16 by default) and reads back as written, together with the enable bit.
- R6: The addend register is at address 1. It reads back as written, and a new value is used from the edge after the write.
- R7: Address 2 returns the low counter word. A read strobe there copies the high counter word of that same cycle into a snapshot. Address 3 returns that snapshot, so a low-then-high read yields one consistent 64-bit instant.
- R8: A write to address 2 only stages the low word and leaves the counter unchanged. A write to address 3 loads {written high word, staged low word} into the counter at that edge.
- R9: A write to address 3 also clears the accumulator, so counting restarts on a clean phase.
- R10: With an addend of 0 the counter does not advance even while enabled.
- R11: When a high-word write and a tick fall on the same edge, the loaded value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (takes the high-word snapshot at address 2) |
| bus_addr | input | 2 | Register address: 0 control, 1 addend, 2 count low, 3 count high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |

## Verification
Read data is combinational, so a counter read reflects the state left by the last edge. A write takes effect at the edge that ends its cycle, so a high-word load sets the time to its base value with zero ticks counted. The bench counts the edges from that load to the sample point, k, and expects base + period*floor(k*A/2^32). The high word is returned one bus cycle after the low read, and is expected to equal the low read's instant rather than the live count. A control or addend change applies from the next edge, and the disabled-hold checks read twice across an idle window.

// File: rtl/ns_timebase_pkg.sv
package ns_timebase_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_ADDEND = 2'd1,
    SEL_CNT_LO = 2'd2,
    SEL_CNT_HI = 2'd3
  } reg_sel_e;

  // Accumulator step: returns {carry, sum}.
  function automatic logic [32:0] phase_step(input logic [31:0] acc, input logic [31:0] add);
    phase_step = {1'b0, acc} + {1'b0, add};
  endfunction

  // Counter advance by one nominal period.
  function automatic logic [63:0] ns_advance(input logic [63:0] cnt, input logic [63:0] step);
    ns_advance = cnt + step;
  endfunction

endpackage

// File: rtl/ts_phase_acc.sv
module ts_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             clear,
  input  logic [ACC_W-1:0] addend,
  output logic [ACC_W-1:0] acc,
  output logic             tick
);
  import ns_timebase_pkg::*;

  logic [ACC_W:0] sum;

  always_comb begin
    sum = ACC_W'(0);
    sum = phase_step(acc, addend);
  end

  assign tick = enable & sum[ACC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc <= '0;
    else if (clear)  acc <= '0;
    else if (enable) acc <= sum[ACC_W-1:0];
  end
endmodule

// File: rtl/ts_ns_counter.sv
module ts_ns_counter #(
  parameter int CNT_W    = 64,
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                load,
  input  logic [CNT_W-1:0]    load_val,
  input  logic [PERIOD_W-1:0] period,
  output logic [CNT_W-1:0]    count
);
  import ns_timebase_pkg::*;

  logic [CNT_W-1:0] step;
  assign step = CNT_W'(period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (load)  count <= load_val;
    else if (tick)  count <= ns_advance(count, step);
  end
endmodule

// File: rtl/ts_regs.sv
module ts_regs #(
  parameter int BUS_W      = 32,
  parameter int PERIOD_W   = 8,
  parameter int PERIOD_LSB = 16,
  localparam int CNT_W     = 2 * BUS_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [1:0]          bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic [CNT_W-1:0]    count,
  output logic                enable,
  output logic [PERIOD_W-1:0] period,
  output logic [BUS_W-1:0]    addend,
  output logic                hi_load,
  output logic [CNT_W-1:0]    load_val,
  output logic                rd_lo,
  output logic [BUS_W-1:0]    hi_snap,
  output logic [BUS_W-1:0]    lo_stage
);
  import ns_timebase_pkg::*;

  reg_sel_e sel;
  assign sel = reg_sel_e'(bus_addr);

  assign hi_load  = bus_wr && (sel == SEL_CNT_HI);
  assign rd_lo    = bus_rd && (sel == SEL_CNT_LO);
  assign load_val = {bus_wdata, lo_stage};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable   <= 1'b0;
      period   <= '0;
      addend   <= '0;
      lo_stage <= '0;
    end else if (bus_wr) begin
      case (sel)
        SEL_CTRL: begin
          enable <= bus_wdata[0];
          period <= bus_wdata[PERIOD_LSB +: PERIOD_W];
        end
        SEL_ADDEND: addend   <= bus_wdata;
        SEL_CNT_LO: lo_stage <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_snap <= '0;
    else if (rd_lo) hi_snap <= count[CNT_W-1:BUS_W];
  end

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_CTRL: begin
        bus_rdata[0] = enable;
        bus_rdata[PERIOD_LSB +: PERIOD_W] = period;
      end
      SEL_ADDEND: bus_rdata = addend;
      SEL_CNT_LO: bus_rdata = count[BUS_W-1:0];
      SEL_CNT_HI: bus_rdata = hi_snap;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ns_timebase.sv
module ns_timebase #(
  parameter int BUS_W      = 32,
  parameter int PERIOD_W   = 8,
  parameter int PERIOD_LSB = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata
);
  localparam int CNT_W = 2 * BUS_W;

  logic                enable;
  logic [PERIOD_W-1:0] period;
  logic [BUS_W-1:0]    addend;
  logic                hi_load;
  logic [CNT_W-1:0]    load_val;
  logic                rd_lo;
  logic [BUS_W-1:0]    hi_snap;
  logic [BUS_W-1:0]    lo_stage;
  logic [BUS_W-1:0]    acc;
  logic                tick;
  logic [CNT_W-1:0]    count;

  ts_regs #(.BUS_W(BUS_W), .PERIOD_W(PERIOD_W), .PERIOD_LSB(PERIOD_LSB)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .count(count), .enable(enable), .period(period), .addend(addend),
    .hi_load(hi_load), .load_val(load_val), .rd_lo(rd_lo),
    .hi_snap(hi_snap), .lo_stage(lo_stage)
  );

  ts_phase_acc #(.ACC_W(BUS_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clear(hi_load),
    .addend(addend), .acc(acc), .tick(tick)
  );

  ts_ns_counter #(.CNT_W(CNT_W), .PERIOD_W(PERIOD_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(hi_load),
    .load_val(load_val), .period(period), .count(count)
  );
endmodule

// File: rtl/ns_timebase_checks.sv
module ns_timebase_checks #(
  parameter int BUS_W    = 32,
  parameter int PERIOD_W = 8,
  localparam int CNT_W   = 2 * BUS_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                enable,
  input logic                tick,
  input logic                hi_load,
  input logic                rd_lo,
  input logic [PERIOD_W-1:0] period,
  input logic [BUS_W-1:0]    addend,
  input logic [BUS_W-1:0]    acc,
  input logic [BUS_W-1:0]    hi_snap,
  input logic [BUS_W-1:0]    lo_stage,
  input logic [BUS_W-1:0]    bus_wdata,
  input logic [CNT_W-1:0]    count
);
  assert_acc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !hi_load) |=> acc == BUS_W'($past(acc) + $past(addend)));

  assert_tick_adds_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hi_load) |=> count == $past(count) + CNT_W'($past(period)));

  assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !hi_load) |=> $stable(count));

  assert_disabled_acc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !hi_load) |=> $stable(acc));

  assert_snapshot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> hi_snap == $past(count[CNT_W-1:BUS_W]));

  assert_load_value_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hi_load |=> count == {$past(bus_wdata), $past(lo_stage)});

  assert_load_clears_acc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hi_load |=> acc == '0);

  assert_zero_addend_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (addend == '0) |-> !tick);
endmodule

bind ns_timebase ns_timebase_checks #(.BUS_W(BUS_W), .PERIOD_W(PERIOD_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .hi_load(hi_load),
  .rd_lo(rd_lo), .period(period), .addend(addend), .acc(acc), .hi_snap(hi_snap),
  .lo_stage(lo_stage), .bus_wdata(bus_wdata), .count(count)
);

// File: tb/ns_timebase_test.sv
`timescale 1ns/1ps
module ns_timebase_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  ns_timebase uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #3 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_time(output logic [63:0] t);
    logic [31:0] lo, hi;
    rd(2'd2, lo);
    rd(2'd3, hi);
    t = {hi, lo};
  endtask

  function automatic logic [31:0] ctrl_word(input logic [7:0] per, input logic en);
    return {8'h00, per, 15'h0, en};
  endfunction

  // Expected time k edges after a load, from a cleared phase.
  function automatic logic [63:0] expect_t(input logic [63:0] base, input logic [7:0] per,
                                           input logic [31:0] add, input int k);
    logic [63:0] prod;
    prod = 64'(k) * 64'(add);
    return base + 64'(per) * (prod >> 32);
  endfunction

  function automatic logic [31:0] pick_add(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h4000_0000;
      2: return 32'h8000_0000;
      3: return 32'h5555_5556;
      4: return 32'hCCCC_CCCD;
      5: return 32'hFFFF_FFFF;
      default: return 32'h028F_5C29;
    endcase
  endfunction

  function automatic logic [7:0] pick_per(input int i);
    case (i)
      0: return 8'd1;
      1: return 8'd8;
      2: return 8'd40;
      default: return 8'd255;
    endcase
  endfunction

  function automatic int pick_wait(input int i);
    case (i)
      0: return 0;
      1: return 1;
      2: return 5;
      3: return 37;
      default: return 100;
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] t, t2, base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); check("R1 ctrl", 64'(d), 64'h0);
    rd(2'd1, d); check("R1 addend", 64'(d), 64'h0);
    rd_time(t);  check("R1 count", t, 64'h0);

    // R5 / R6 readback
    wr(2'd0, ctrl_word(8'hA5, 1'b1));
    rd(2'd0, d); check("R5 ctrl readback", 64'(d), 64'(ctrl_word(8'hA5, 1'b1)));
    wr(2'd1, 32'h1234_5678);
    rd(2'd1, d); check("R6 addend readback", 64'(d), 64'h1234_5678);

    // R2 R3 R10 R11 sweep over addend, period and wait
    for (int ai = 0; ai < 7; ai++) begin
      for (int pi = 0; pi < 4; pi++) begin
        for (int mi = 0; mi < 5; mi++) begin
          base = {32'(ai * 20 + pi * 5 + mi), 32'hFFFF_FF00};
          wr(2'd0, ctrl_word(pick_per(pi), 1'b1));
          wr(2'd1, pick_add(ai));
          wr(2'd2, base[31:0]);
          wr(2'd3, base[63:32]);   // R11: a pending tick at this edge must lose
          repeat (pick_wait(mi)) @(negedge clk);
          rd_time(t);
          check(ai == 0 ? "R10 zero addend" : "R2 R3 sweep",
                t, expect_t(base, pick_per(pi), pick_add(ai), pick_wait(mi)));
        end
      end
    end

    // R7 atomic read across a carry into the high word
    base = 64'h0000_0001_FFFF_FFF0;
    wr(2'd0, ctrl_word(8'd8, 1'b1));
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd2, base[31:0]);
    wr(2'd3, base[63:32]);
    repeat (2) @(negedge clk);
    rd_time(t);
    check("R7 atomic pair", t, 64'h0000_0001_FFFF_FFF8);

    // R4 disabled hold, R9 clean phase after load
    base = 64'h0000_0042_0000_1000;
    wr(2'd0, ctrl_word(8'd40, 1'b0));
    wr(2'd1, 32'h4000_0000);
    wr(2'd2, base[31:0]);
    wr(2'd3, base[63:32]);
    repeat (20) @(negedge clk);
    rd_time(t);
    check("R4 disabled hold", t, base);
    rd(2'd0, d); check("R5 period kept while disabled", 64'(d), 64'(ctrl_word(8'd40, 1'b0)));
    wr(2'd0, ctrl_word(8'd40, 1'b1));
    repeat (9) @(negedge clk);
    rd_time(t);
    check("R9 phase from zero", t, base + 64'd80);

    // R4 write zero to control stops, R8 low write staged only
    wr(2'd0, 32'h0);
    rd_time(t);
    repeat (30) @(negedge clk);
    rd_time(t2);
    check("R4 stopped", t2, t);
    wr(2'd2, 32'hDEAD_BEEF);
    rd_time(t2);
    check("R8 low write staged", t2, t);
    wr(2'd3, 32'h0000_0777);
    rd_time(t2);
    check("R8 high write loads", t2, 64'h0000_0777_DEAD_BEEF);

    // R6 addend change applies from next edge
    wr(2'd0, ctrl_word(8'd3, 1'b1));
    wr(2'd1, 32'h0);
    wr(2'd2, 32'h0000_0000);
    wr(2'd3, 32'h0000_0010);
    wr(2'd1, 32'h8000_0000);   // one edge with addend 0 after load
    repeat (4) @(negedge clk); // four edges at half rate
    rd_time(t);
    check("R6 addend switch", t, 64'h0000_0010_0000_0006);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule